// File: doc/BRIEF.md
# Serial Block-Write Control Register File

This block is an I2C target that holds seven 8-bit control registers and drives them onto a parallel output bus for the logic around it. A controller addresses the block with its 7-bit device address. On a write, the controller first sends two header bytes, a command byte and a count byte. The block acknowledges both and ignores their values. Every byte after the header is stored in the next register, starting at register 0 and moving up by one each time. Bytes sent after the last register are acknowledged and thrown away.

On a read, the block first returns the register count. It then returns register 0 upward, most significant bit first. Once the registers run out it returns 0xFF. The read ends when the controller answers a byte with NACK.

SCL and SDA are sampled on the system clock through a two-flop synchronizer. SDA is driven only low, through an open-drain enable. Register reset values apply only on power-on reset.

Top module: `i2c_blkwr_regfile`

## Requirements
- R1: After reset, register k appears on `regs_o[8k+7:8k]` with these values: reg0 0x00, reg1 0xFF, reg2 0x7F, reg3 0xFF, reg4 0x0F, reg5 0x13, reg6 0x00.
- R2: The first byte after a START holds the 7-bit device address in bits 7:1 (default 0x69) and the direction in bit 0 (0 write, 1 read). The block acknowledges it, by pulling SDA low in the ninth clock, only when the address matches. On a mismatch it acknowledges nothing and changes no register until the next START.
- R3: On a write, the two bytes that follow the address (command and count) are acknowledged, and their values affect neither the registers nor where data is stored.
- R4: Data bytes after the header are acknowledged and written to reg0, reg1, reg2 and so on, one register per byte. The new value shows on `regs_o`.
- R5: Data bytes after reg6 has been written are acknowledged and leave every register unchanged.
- R6: A STOP or a repeated START ends the transfer. The next write stores its first data byte in reg0 again.
- R7: On a read, the bytes come out MSB first in this order: the register count (7), then reg0 through reg6, then 0xFF for every further byte.
- R8: A NACK from the controller after a read byte ends the read. SDA stays released until the next START.
- R9: `sda_oe_o` changes only after an SCL falling edge, a START or a STOP, and it is low while the bus is idle.
- R10: A START or STOP is recognised only as an SDA edge while SCL is high. SDA changes while SCL is low do not end a write in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the serial lines |
| rst_ni | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High to pull SDA low (open drain) |
| regs_o | output | NUM_REGS*8 | Register contents, reg k in bits 8k+7:8k |

## Verification
The assertions assume that SCL comes from a single controller that never stretches the clock. They also assume that each SCL phase and each SDA setup and hold time lasts longer than the synchronizer delay plus one cycle, so every bus edge appears as exactly one event. The bench drives a bus model in which SCL stays high or low for 8 to 16 system clocks and SDA changes only while SCL is low, except on purpose for START and STOP. The bench builds SDA as a wired AND of the controller and the block, so the block's acknowledge and read bits are seen only through the bus line.

// File: rtl/i2c_regf_pkg.sv
`timescale 1ns/1ps
package i2c_regf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_e;

  typedef enum logic [1:0] {
    SG_ADDR,
    SG_CMD,
    SG_CNT,
    SG_DATA
  } stage_e;

  // Power-on value of register idx
  function automatic logic [7:0] reg_reset_value(input int unsigned idx);
    case (idx)
      1:       return 8'hFF;
      2:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'h0F;
      5:       return 8'h13;
      default: return 8'h00;
    endcase
  endfunction

  // Byte sent on read slot ptr: count first, then registers, then filler
  function automatic logic [7:0] pick_tx_byte(input int unsigned ptr,
                                              input int unsigned nregs,
                                              input logic [7:0]  rd);
    if (ptr == 0)          return nregs[7:0];
    else if (ptr <= nregs) return rd;
    else                   return 8'hFF;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
`timescale 1ns/1ps
module i2c_reg_bank
  import i2c_regf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS-1:0]   wr_vec_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [7:0] q;
      assign wr_vec_o[g] = wr_en_i && (wr_idx_i == IDX_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          q <= reg_reset_value(g);
        else if (wr_vec_o[g]) q <= wr_data_i;
      end
      assign regs_o[g*8 +: 8] = q;
    end
  endgenerate

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs_o[i*8 +: 8];
    end
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
`timescale 1ns/1ps
module i2c_slave_fsm
  import i2c_regf_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned PTR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o,
  output logic             nack_end_o
);
  localparam logic [PTR_W-1:0] NREG_P  = PTR_W'(NUM_REGS);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NUM_REGS + 1);

  phase_e           phase_q;
  stage_e           stage_q;
  logic [7:0]       shreg_q;
  logic [3:0]       bitcnt_q;
  logic             rd_mode_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_m1;
  logic             oe_q;
  logic             nack_q;
  logic             wr_en_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [7:0]       wr_data_q;
  logic             nack_end_q;
  logic [7:0]       tx_byte;
  logic             byte_done;

  assign ptr_m1    = ptr_q - PTR_W'(1);
  assign rd_idx_o  = ptr_m1[IDX_W-1:0];
  assign tx_byte   = pick_tx_byte(32'(ptr_q), NUM_REGS, rd_data_i);
  assign byte_done = scl_fall_i && (bitcnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      stage_q    <= SG_ADDR;
      shreg_q    <= 8'h00;
      bitcnt_q   <= 4'd0;
      rd_mode_q  <= 1'b0;
      ptr_q      <= '0;
      oe_q       <= 1'b0;
      nack_q     <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_idx_q   <= '0;
      wr_data_q  <= 8'h00;
      nack_end_q <= 1'b0;
    end else begin
      wr_en_q    <= 1'b0;
      nack_end_q <= 1'b0;
      if (start_i) begin
        phase_q   <= PH_RX;
        stage_q   <= SG_ADDR;
        bitcnt_q  <= 4'd0;
        rd_mode_q <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        phase_q <= PH_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (phase_q)
          PH_RX: begin
            if (scl_rise_i && bitcnt_q != 4'd8) begin
              shreg_q  <= {shreg_q[6:0], sda_s_i};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (byte_done) begin
              bitcnt_q <= 4'd0;
              if (stage_q == SG_ADDR && shreg_q[7:1] != DEV_ADDR) begin
                phase_q <= PH_IDLE;
              end else begin
                phase_q <= PH_ACK;
                oe_q    <= 1'b1;
              end
              case (stage_q)
                SG_ADDR: begin
                  rd_mode_q <= shreg_q[0];
                  ptr_q     <= '0;
                  stage_q   <= SG_CMD;
                end
                SG_CMD:  stage_q <= SG_CNT;
                SG_CNT:  stage_q <= SG_DATA;
                default: begin
                  if (ptr_q < NREG_P) begin
                    wr_en_q   <= 1'b1;
                    wr_idx_q  <= ptr_q[IDX_W-1:0];
                    wr_data_q <= shreg_q;
                  end
                  if (ptr_q != PTR_MAX) ptr_q <= ptr_q + PTR_W'(1);
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall_i) begin
              if (rd_mode_q) begin
                phase_q  <= PH_TX;
                shreg_q  <= tx_byte;
                oe_q     <= ~tx_byte[7];
                bitcnt_q <= 4'd0;
                if (ptr_q != PTR_MAX) ptr_q <= ptr_q + PTR_W'(1);
              end else begin
                phase_q <= PH_RX;
                oe_q    <= 1'b0;
              end
            end
          end
          PH_TX: begin
            if (scl_fall_i) begin
              if (bitcnt_q == 4'd7) begin
                phase_q <= PH_MACK;
                oe_q    <= 1'b0;
              end else begin
                shreg_q  <= {shreg_q[6:0], 1'b0};
                oe_q     <= ~shreg_q[6];
                bitcnt_q <= bitcnt_q + 4'd1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise_i) nack_q <= sda_s_i;
            if (scl_fall_i) begin
              if (nack_q) begin
                phase_q    <= PH_IDLE;
                nack_end_q <= 1'b1;
              end else begin
                phase_q  <= PH_TX;
                shreg_q  <= tx_byte;
                oe_q     <= ~tx_byte[7];
                bitcnt_q <= 4'd0;
                if (ptr_q != PTR_MAX) ptr_q <= ptr_q + PTR_W'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en_o    = wr_en_q;
  assign wr_idx_o   = wr_idx_q;
  assign wr_data_o  = wr_data_q;
  assign sda_oe_o   = oe_q;
  assign nack_end_o = nack_end_q;
endmodule

// File: rtl/i2c_blkwr_regfile.sv
`timescale 1ns/1ps
module i2c_blkwr_regfile #(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned NUM_REGS    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int unsigned PTR_W = $clog2(NUM_REGS + 2);

  logic                sda_s;
  logic                scl_rise, scl_fall, start_det, stop_det;
  logic                wr_en, nack_end, sda_oe;
  logic [IDX_W-1:0]    wr_idx, rd_idx;
  logic [7:0]          wr_data, rd_data;
  logic [NUM_REGS-1:0] wr_vec;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_slave_fsm #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .PTR_W    (PTR_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_data_i  (rd_data),
    .rd_idx_o   (rd_idx),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe),
    .nack_end_o (nack_end)
  );

  i2c_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .wr_vec_o  (wr_vec),
    .regs_o    (regs_o)
  );

  assign sda_oe_o = sda_oe;
endmodule

// File: rtl/i2c_blkwr_regfile_chk.sv
`timescale 1ns/1ps
module i2c_blkwr_regfile_chk #(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned IDX_W    = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                scl_fall,
  input logic                start_det,
  input logic                stop_det,
  input logic                nack_end,
  input logic                sda_oe,
  input logic                wr_en,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [NUM_REGS-1:0] wr_vec
);
  // R9: the open-drain enable only moves after an SCL fall, START or STOP
  a_r9_oe_moves_on_scl_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R6: a STOP releases the line
  a_r6_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe);

  // R6: a START (first or repeated) releases the line
  a_r6_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe);

  // R8: controller NACK leaves SDA released
  a_r8_nack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_end |=> !sda_oe);

  // R5: a write never targets a slot past the last register
  a_r5_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (32'(wr_idx) < NUM_REGS));

  // R4: each stored byte lands in exactly one register
  a_r4_one_register_per_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> ($countones(wr_vec) == 1));

  a_r4_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |-> (wr_vec == '0));
endmodule

bind i2c_blkwr_regfile i2c_blkwr_regfile_chk #(
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .nack_end  (nack_end),
  .sda_oe    (sda_oe),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_vec    (wr_vec)
);

// File: tb/i2c_blkwr_regfile_tb.sv
`timescale 1ns/1ps
module i2c_blkwr_regfile_tb;
  localparam int NR = 7;
  localparam int Q  = 8;
  localparam int H  = 16;
  localparam logic [7:0] ADDR_W = 8'hD2;
  localparam logic [7:0] ADDR_R = 8'hD3;
  localparam int NV = 4;
  localparam int VLEN [NV] = '{3, 7, 9, 0};
  localparam logic [7:0] VDAT [NV][9] = '{
    '{8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'h00, 8'h00},
    '{8'h5A, 8'hC3, 8'h3C, 8'h96, 8'h69, 8'hF0, 8'h0F, 8'hE1, 8'h1E},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  logic [NR*8-1:0] regs;
  wire  sda_bus = ~(m_sda_low | sda_oe);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] model [NR];
  logic [7:0] rb [12];

  always #2 clk = ~clk;

  i2c_blkwr_regfile u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wait_cyc(Q);
    m_scl = 1'b1;     wait_cyc(Q);
    m_sda_low = 1'b1; wait_cyc(Q);
    m_scl = 1'b0;     wait_cyc(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wait_cyc(Q);
    m_scl = 1'b1;     wait_cyc(Q);
    m_sda_low = 1'b0; wait_cyc(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; wait_cyc(Q);
      m_scl = 1'b1;      wait_cyc(H);
      m_scl = 1'b0;      wait_cyc(Q);
    end
    m_sda_low = 1'b0; wait_cyc(Q);
    m_scl = 1'b1;     wait_cyc(Q);
    ack = ~sda_bus;   wait_cyc(Q);
    m_scl = 1'b0;     wait_cyc(Q);
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_cyc(Q);
      m_scl = 1'b1; wait_cyc(Q);
      b[i] = sda_bus; wait_cyc(Q);
      m_scl = 1'b0;
    end
    m_sda_low = ~last; wait_cyc(Q);
    m_scl = 1'b1;      wait_cyc(H);
    m_scl = 1'b0;      wait_cyc(Q);
    m_sda_low = 1'b0;
  endtask

  // Header of a write: address, command, count (values chosen to look like an offset)
  task automatic wr_header(input string req);
    logic a;
    wr_byte(ADDR_W, a); chk({req, " R2 address ack"}, 32'(a), 32'd1);
    wr_byte(8'h05, a);  chk("R3 command byte ack", 32'(a), 32'd1);
    wr_byte(8'h02, a);  chk("R3 count byte ack", 32'(a), 32'd1);
  endtask

  task automatic read_n(input int n);
    logic a;
    bus_start();
    wr_byte(ADDR_R, a); chk("R2 read address ack", 32'(a), 32'd1);
    for (int k = 0; k < n; k++) rd_byte(k == n - 1, rb[k]);
    bus_stop();
  endtask

  task automatic cmp_regs(input string req);
    for (int k = 0; k < NR; k++) chk(req, 32'(regs[k*8 +: 8]), 32'(model[k]));
  endtask

  task automatic cmp_readback();
    read_n(NR + 1);
    chk("R7 count byte first", 32'(rb[0]), 32'(NR));
    for (int k = 0; k < NR; k++) chk("R7 register readback", 32'(rb[k+1]), 32'(model[k]));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    logic a;
    model = '{8'h00, 8'hFF, 8'h7F, 8'hFF, 8'h0F, 8'h13, 8'h00};
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1 reset state, R9 idle line
    cmp_regs("R1 reset value");
    chk("R9 idle oe low", 32'(sda_oe), 32'd0);
    cmp_readback();

    // Table walk: write vectors, compare outputs and readback against the model
    for (int v = 0; v < NV; v++) begin
      bus_start();
      wr_header("R4");
      for (int k = 0; k < VLEN[v]; k++) begin
        wr_byte(VDAT[v][k], a);
        if (k < NR) begin
          model[k] = VDAT[v][k];
          chk("R4 data byte ack", 32'(a), 32'd1);
        end else begin
          chk("R5 extra byte ack", 32'(a), 32'd1);
        end
      end
      bus_stop();
      wait_cyc(Q);
      chk("R9 oe low after stop", 32'(sda_oe), 32'd0);
      cmp_regs("R4 R5 register contents");
      cmp_readback();
    end

    // R2 address mismatch: no ack, no change
    bus_start();
    wr_byte(8'h24, a); chk("R2 foreign address nack", 32'(a), 32'd0);
    wr_byte(8'h00, a); chk("R2 ignored byte nack", 32'(a), 32'd0);
    wr_byte(8'h99, a); chk("R2 ignored byte nack", 32'(a), 32'd0);
    wr_byte(8'h77, a); chk("R2 ignored byte nack", 32'(a), 32'd0);
    bus_stop();
    cmp_regs("R2 mismatch leaves registers");

    // R6 repeated start restarts at reg0
    bus_start();
    wr_header("R6");
    wr_byte(8'hD1, a);
    wr_byte(8'hD2, a);
    bus_start();
    wr_header("R6");
    wr_byte(8'hE1, a);
    bus_stop();
    model[0] = 8'hE1;
    model[1] = 8'hD2;
    chk("R6 restart writes reg0", 32'(regs[7:0]), 32'hE1);
    chk("R6 earlier byte kept in reg1", 32'(regs[15:8]), 32'hD2);

    // R10 SDA toggling while SCL low is not a START/STOP
    bus_start();
    wr_header("R10");
    for (int t = 0; t < 4; t++) begin
      m_sda_low = ~m_sda_low; wait_cyc(Q);
    end
    wr_byte(8'h77, a);
    chk("R10 write survives SDA toggles", 32'(a), 32'd1);
    wr_byte(8'h78, a);
    bus_stop();
    model[0] = 8'h77;
    model[1] = 8'h78;
    cmp_regs("R10 register contents");

    // R7 reading past the registers, R8 NACK ends read
    bus_start();
    wr_byte(ADDR_R, a); chk("R2 read address ack", 32'(a), 32'd1);
    for (int k = 0; k < 10; k++) rd_byte(k == 9, rb[k]);
    chk("R7 count byte", 32'(rb[0]), 32'(NR));
    chk("R7 reg0 on read", 32'(rb[1]), 32'h77);
    chk("R7 reg6 on read", 32'(rb[7]), 32'(model[6]));
    chk("R7 filler after last register", 32'(rb[8]), 32'hFF);
    chk("R7 filler after last register", 32'(rb[9]), 32'hFF);
    wait_cyc(H);
    chk("R8 oe low after nack", 32'(sda_oe), 32'd0);
    m_scl = 1'b1; wait_cyc(Q);
    chk("R8 bus released after nack", 32'(sda_bus), 32'd1);
    m_scl = 1'b0; wait_cyc(Q);
    bus_stop();

    // R8 a short read with NACK on the first byte, then a write still works
    read_n(1);
    chk("R8 single byte read count", 32'(rb[0]), 32'(NR));
    bus_start();
    wr_header("R8");
    wr_byte(8'h3E, a);
    bus_stop();
    chk("R8 write after nack read", 32'(regs[7:0]), 32'h3E);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule